// File: doc/BRIEF.md
# Trigger-Controlled Timebase Counter

This block is the shared 16-bit time reference of a timer/PWM peripheral. A clock source selector picks either the internal counter clock or rising edges of an external clock pin (first synchronized into the counter clock domain). A power-of-two prescaler divides the chosen events. The counter then runs against a programmable modulo. It counts either upward with a wrap to zero, or up to the modulo and back down to zero. Each time the count returns to zero it sets an overflow flag, and the flag can drive an interrupt request.

A trigger can gate the counter in three ways: it can hold the counter after enable until the trigger fires, it can restart the counter after a stop at overflow, and it can reload the count to zero. The trigger comes from one of two places. The first is an external pin behind a synchronizer. The second is the OR of channel capture pulses picked by a 4-bit mask. The polarity of the active edge is programmable. Doze and debug indicators can freeze the counter, and while it is frozen, trigger edges are discarded. All control fields arrive as plain ports from a register block outside this one.

Top module: `trig_timebase`

## Requirements
- R1: After reset the count is 0, and both the overflow flag and the interrupt request are low.
- R2: With clock mode 01, the count advances once every 2^prescaleSel counter clocks (prescaleSel 0..7 gives 1..128). With clock mode 00 (or the unused 11) the count holds.
- R3: With centerAlign 0, the count steps by +1 and goes from modulo (or above) to 0. That wrap sets the overflow flag.
- R4: With centerAlign 1, the count runs 0, 1, ..., modulo, modulo-1, ..., 0. The flag is set on each return to 0, and counting then turns upward again.
- R5: With clock mode 10, each rising edge of extClkPin produces exactly one counting event, however long the pin stays high.
- R6: ovfIrq is high exactly when the flag and ovfIrqEn are both 1. A pulse on ovfClear clears the flag. A pulse on countWrite zeroes the count and the prescaler on the next edge.
- R7: With startOnTrig 1, an enabled counter stays at its value until an active trigger edge arrives.
- R8: With stopOnOvf 1, the counter stops at 0 after an overflow. If startOnTrig is also 1, the next active trigger edge restarts it.
- R9: With reloadOnTrig 1, an active trigger edge loads 0 on the next clock edge. When it falls on the same edge as a wrap, the reload wins and the overflow flag stays unchanged.
- R10: trigInternal 0 selects the synchronized extTrigPin. trigInternal 1 selects the OR of chanCapture bits whose trigMask bit (bit i for channel i) is 1. trigActiveLow 0 triggers on a rising edge of the selected signal, and 1 triggers on a falling edge.
- R11: The counter, prescaler and trigger handling freeze while dozeActive and dozePauseEn are both 1. They also freeze while debugActive is 1 and debugRunMode is not 11. Trigger edges seen while frozen are lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rstN | input | 1 | Asynchronous active-low reset |
| prescaleSel | input | 3 | Prescale exponent, divide by 2^value |
| clkMode | input | 2 | 00 off, 01 counter clock, 10 external pin edges, 11 off |
| centerAlign | input | 1 | 0 up counting, 1 up-down counting |
| modulo | input | 16 | Terminal count value |
| ovfIrqEn | input | 1 | Overflow interrupt enable |
| startOnTrig | input | 1 | Wait for trigger after enable or stop |
| stopOnOvf | input | 1 | Stop counting after overflow |
| reloadOnTrig | input | 1 | Trigger edge zeroes the count |
| trigActiveLow | input | 1 | Trigger edge polarity, 1 means falling |
| trigInternal | input | 1 | 1 selects masked channel captures |
| trigMask | input | 4 | Channel capture selection mask |
| dozePauseEn | input | 1 | Allow doze to freeze the counter |
| debugRunMode | input | 2 | 11 keeps running in debug, other values freeze |
| dozeActive | input | 1 | System doze indicator |
| debugActive | input | 1 | Debug halt indicator |
| extClkPin | input | 1 | Asynchronous external clock pin |
| extTrigPin | input | 1 | Asynchronous external trigger pin |
| chanCapture | input | 4 | Synchronous capture pulses from channels 0..3 |
| countWrite | input | 1 | Pulse: zero count and prescaler |
| ovfClear | input | 1 | Pulse: clear the overflow flag |
| count | output | 16 | Current counter value |
| ovfFlag | output | 1 | Overflow flag |
| ovfIrq | output | 1 | Overflow interrupt request |

## Verification
A trigger reload and a modulo wrap can land on the same clock edge. The bench provokes this by waiting until the count reads the modulo value and then pulsing a masked channel capture in that cycle, so that the reload and the wrap share one edge. It judges the outcome in two ways. After that edge the count must be 0 with the overflow flag still clear. Two edges later the count must read 2, which shows that counting resumed normally from the reload.

// File: rtl/trig_timebase_pkg.sv
package trig_timebase_pkg;

  typedef enum logic [1:0] {
    CLK_OFF = 2'b00,
    CLK_INT = 2'b01,
    CLK_EXT = 2'b10,
    CLK_RSV = 2'b11
  } clk_mode_e;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic tick;    // advance the counter by one step
    logic reload;  // trigger reload to zero
    logic zero;    // direct count write to zero
  } tb_strobe_t;

endpackage

// File: rtl/trig_timebase_sync.sv
module trig_timebase_sync #(
  parameter int Stages = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [Stages-1:0] pipe;

  generate
    if (Stages == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '0;
        else       pipe <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '0;
        else       pipe <= {pipe[Stages-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[Stages-1];
endmodule

// File: rtl/trig_timebase_ctrl.sv
module trig_timebase_ctrl
  import trig_timebase_pkg::*;
#(
  parameter int PsWidth   = 3,
  parameter int CapWidth  = 4,
  parameter int SyncDepth = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PsWidth-1:0]  prescaleSel,
  input  logic [1:0]          clkMode,
  input  logic                startOnTrig,
  input  logic                stopOnOvf,
  input  logic                reloadOnTrig,
  input  logic                trigActiveLow,
  input  logic                trigInternal,
  input  logic [CapWidth-1:0] trigMask,
  input  logic                dozePauseEn,
  input  logic [1:0]          debugRunMode,
  input  logic                dozeActive,
  input  logic                debugActive,
  input  logic                extClkPin,
  input  logic                extTrigPin,
  input  logic [CapWidth-1:0] chanCapture,
  input  logic                countWrite,
  input  logic                ovfEvent,
  output tb_strobe_t          strobe
);
  localparam int PsCntW = (2 ** PsWidth) - 1;

  clk_mode_e         mode;
  logic              extClkSync, extClkPrev, extClkEdge;
  logic              extTrigSync, trigRaw, trigPrev, trigEdgeRaw, trigEdge;
  logic              frozen, enabled, srcEvent, running, advance;
  logic              hold, psDone, reloadNow;
  logic [PsCntW-1:0] psCnt, psMask;

  assign mode = clk_mode_e'(clkMode);

  trig_timebase_sync #(.Stages(SyncDepth)) u_clkSync (
    .clk(clk), .rstN(rstN), .din(extClkPin), .dout(extClkSync));

  trig_timebase_sync #(.Stages(SyncDepth)) u_trigSync (
    .clk(clk), .rstN(rstN), .din(extTrigPin), .dout(extTrigSync));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extClkPrev <= 1'b0;
      trigPrev   <= 1'b0;
    end else begin
      extClkPrev <= extClkSync;
      trigPrev   <= trigRaw;
    end
  end

  assign extClkEdge  = extClkSync & ~extClkPrev;
  assign trigRaw     = trigInternal ? |(chanCapture & trigMask) : extTrigSync;
  assign trigEdgeRaw = trigActiveLow ? (~trigRaw & trigPrev) : (trigRaw & ~trigPrev);

  assign frozen   = (dozePauseEn & dozeActive) | (debugActive & (debugRunMode != 2'b11));
  assign enabled  = (mode == CLK_INT) | (mode == CLK_EXT);
  assign trigEdge = trigEdgeRaw & enabled & ~frozen;

  assign srcEvent = (mode == CLK_INT) | ((mode == CLK_EXT) & extClkEdge);
  assign running  = enabled & ~frozen & ~hold & ~countWrite;
  assign advance  = running & srcEvent;

  assign psMask    = ~({PsCntW{1'b1}} << prescaleSel);
  assign psDone    = (psCnt & psMask) == psMask;
  assign reloadNow = reloadOnTrig & trigEdge & ~countWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt <= '0;
    end else if (countWrite || reloadNow) begin
      psCnt <= '0;
    end else if (advance) begin
      psCnt <= psCnt + 1'b1;
    end
  end

  // run gate: armed by enable or overflow stop, released by trigger
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hold <= 1'b0;
    end else if (!enabled) begin
      hold <= startOnTrig;
    end else if (trigEdge && startOnTrig) begin
      hold <= 1'b0;
    end else if (ovfEvent && stopOnOvf) begin
      hold <= 1'b1;
    end
  end

  assign strobe.tick   = advance & psDone & ~reloadNow;
  assign strobe.reload = reloadNow;
  assign strobe.zero   = countWrite;
endmodule

// File: rtl/trig_timebase_dp.sv
module trig_timebase_dp
  import trig_timebase_pkg::*;
#(
  parameter int CntWidth = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  tb_strobe_t          strobe,
  input  logic                centerAlign,
  input  logic [CntWidth-1:0] modulo,
  input  logic                ovfClear,
  output logic [CntWidth-1:0] count,
  output logic                ovfFlag,
  output logic                ovfEvent
);
  logic                downDir, nextDown, wrapEv, atTop;
  logic [CntWidth-1:0] nextCount, decCount;

  assign atTop    = count >= modulo;
  assign decCount = (count == '0) ? '0 : count - CntWidth'(1);

  always_comb begin
    nextCount = count + CntWidth'(1);
    nextDown  = 1'b0;
    wrapEv    = 1'b0;
    if (!centerAlign) begin
      if (atTop) begin
        nextCount = '0;
        wrapEv    = 1'b1;
      end
    end else if (downDir || atTop) begin
      nextCount = decCount;
      wrapEv    = (decCount == '0);
      nextDown  = (decCount != '0);
    end
  end

  assign ovfEvent = strobe.tick & wrapEv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      downDir <= 1'b0;
    end else if (strobe.zero || strobe.reload) begin
      count   <= '0;
      downDir <= 1'b0;
    end else if (strobe.tick) begin
      count   <= nextCount;
      downDir <= nextDown;
    end else if (!centerAlign) begin
      downDir <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         ovfFlag <= 1'b0;
    else if (ovfEvent) ovfFlag <= 1'b1;
    else if (ovfClear) ovfFlag <= 1'b0;
  end
endmodule

// File: rtl/trig_timebase.sv
module trig_timebase
  import trig_timebase_pkg::*;
#(
  parameter int CntWidth = 16,
  parameter int PsWidth  = 3,
  parameter int CapWidth = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PsWidth-1:0]  prescaleSel,
  input  logic [1:0]          clkMode,
  input  logic                centerAlign,
  input  logic [CntWidth-1:0] modulo,
  input  logic                ovfIrqEn,
  input  logic                startOnTrig,
  input  logic                stopOnOvf,
  input  logic                reloadOnTrig,
  input  logic                trigActiveLow,
  input  logic                trigInternal,
  input  logic [CapWidth-1:0] trigMask,
  input  logic                dozePauseEn,
  input  logic [1:0]          debugRunMode,
  input  logic                dozeActive,
  input  logic                debugActive,
  input  logic                extClkPin,
  input  logic                extTrigPin,
  input  logic [CapWidth-1:0] chanCapture,
  input  logic                countWrite,
  input  logic                ovfClear,
  output logic [CntWidth-1:0] count,
  output logic                ovfFlag,
  output logic                ovfIrq
);
  tb_strobe_t strobe;
  logic       ovfEvent;

  trig_timebase_ctrl #(.PsWidth(PsWidth), .CapWidth(CapWidth), .SyncDepth(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .prescaleSel(prescaleSel), .clkMode(clkMode),
    .startOnTrig(startOnTrig), .stopOnOvf(stopOnOvf), .reloadOnTrig(reloadOnTrig),
    .trigActiveLow(trigActiveLow), .trigInternal(trigInternal), .trigMask(trigMask),
    .dozePauseEn(dozePauseEn), .debugRunMode(debugRunMode), .dozeActive(dozeActive),
    .debugActive(debugActive), .extClkPin(extClkPin), .extTrigPin(extTrigPin),
    .chanCapture(chanCapture), .countWrite(countWrite), .ovfEvent(ovfEvent),
    .strobe(strobe));

  trig_timebase_dp #(.CntWidth(CntWidth)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .centerAlign(centerAlign),
    .modulo(modulo), .ovfClear(ovfClear), .count(count), .ovfFlag(ovfFlag),
    .ovfEvent(ovfEvent));

  assign ovfIrq = ovfFlag & ovfIrqEn;
endmodule

// File: rtl/trig_timebase_chk.sv
module trig_timebase_chk #(
  parameter int CntWidth = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic [1:0]          clkMode,
  input logic                centerAlign,
  input logic                countWrite,
  input logic                ovfClear,
  input logic                dozePauseEn,
  input logic                dozeActive,
  input logic                debugActive,
  input logic [1:0]          debugRunMode,
  input logic [CntWidth-1:0] count,
  input logic                ovfFlag
);
  logic frozenIn;
  assign frozenIn = (dozePauseEn && dozeActive) || (debugActive && debugRunMode != 2'b11);

  // R2: a disabled counter only moves through a direct write
  p_disabled_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (clkMode == 2'b00 && !countWrite) |=> $stable(count));

  // R3: in up counting the count either steps by one or lands on zero
  p_up_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(centerAlign) && count != $past(count))
      |-> (count == CntWidth'($past(count) + 1'b1) || count == '0));

  // R3/R4: the overflow flag only rises as the count reaches zero
  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> count == '0);

  // R6: after a clear the flag is low unless a new wrap coincided
  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    ovfClear |=> (!ovfFlag || count == '0));

  // R6: a direct write zeroes the count
  p_write_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    countWrite |=> count == '0);

  // R11: frozen counter holds its value
  p_frozen_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (frozenIn && !countWrite) |=> $stable(count));
endmodule

bind trig_timebase trig_timebase_chk #(.CntWidth(CntWidth)) u_chk (
  .clk(clk), .rstN(rstN), .clkMode(clkMode), .centerAlign(centerAlign),
  .countWrite(countWrite), .ovfClear(ovfClear), .dozePauseEn(dozePauseEn),
  .dozeActive(dozeActive), .debugActive(debugActive), .debugRunMode(debugRunMode),
  .count(count), .ovfFlag(ovfFlag));

// File: tb/trig_timebase_test.sv
module trig_timebase_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  prescaleSel = '0;
  logic [1:0]  clkMode = '0;
  logic        centerAlign = 1'b0;
  logic [15:0] modulo = '0;
  logic        ovfIrqEn = 1'b0, startOnTrig = 1'b0, stopOnOvf = 1'b0, reloadOnTrig = 1'b0;
  logic        trigActiveLow = 1'b0, trigInternal = 1'b0;
  logic [3:0]  trigMask = '0;
  logic        dozePauseEn = 1'b0, dozeActive = 1'b0, debugActive = 1'b0;
  logic [1:0]  debugRunMode = 2'b11;
  logic        extClkPin = 1'b0, extTrigPin = 1'b0;
  logic [3:0]  chanCapture = '0;
  logic        countWrite = 1'b0, ovfClear = 1'b0;
  logic [15:0] count;
  logic        ovfFlag, ovfIrq;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  trig_timebase uut (
    .clk(clk), .rstN(rstN), .prescaleSel(prescaleSel), .clkMode(clkMode),
    .centerAlign(centerAlign), .modulo(modulo), .ovfIrqEn(ovfIrqEn),
    .startOnTrig(startOnTrig), .stopOnOvf(stopOnOvf), .reloadOnTrig(reloadOnTrig),
    .trigActiveLow(trigActiveLow), .trigInternal(trigInternal), .trigMask(trigMask),
    .dozePauseEn(dozePauseEn), .debugRunMode(debugRunMode), .dozeActive(dozeActive),
    .debugActive(debugActive), .extClkPin(extClkPin), .extTrigPin(extTrigPin),
    .chanCapture(chanCapture), .countWrite(countWrite), .ovfClear(ovfClear),
    .count(count), .ovfFlag(ovfFlag), .ovfIrq(ovfIrq));

  typedef struct packed {
    logic [2:0]  ps;
    logic [15:0] mdl;
    logic        ctr;
    logic [15:0] cyc;
    logic [15:0] expCnt;
    logic        expFlag;
  } vec_t;

  localparam int NumVec = 7;
  localparam vec_t Vecs [NumVec] = '{
    '{ps: 3'd0, mdl: 16'd9,   ctr: 1'b0, cyc: 16'd25,  expCnt: 16'd5,  expFlag: 1'b1},
    '{ps: 3'd2, mdl: 16'd5,   ctr: 1'b0, cyc: 16'd30,  expCnt: 16'd1,  expFlag: 1'b1},
    '{ps: 3'd0, mdl: 16'd3,   ctr: 1'b1, cyc: 16'd5,   expCnt: 16'd1,  expFlag: 1'b0},
    '{ps: 3'd1, mdl: 16'd4,   ctr: 1'b1, cyc: 16'd17,  expCnt: 16'd0,  expFlag: 1'b1},
    '{ps: 3'd7, mdl: 16'd2,   ctr: 1'b0, cyc: 16'd300, expCnt: 16'd2,  expFlag: 1'b0},
    '{ps: 3'd0, mdl: 16'd0,   ctr: 1'b0, cyc: 16'd4,   expCnt: 16'd0,  expFlag: 1'b1},
    '{ps: 3'd3, mdl: 16'd100, ctr: 1'b0, cyc: 16'd80,  expCnt: 16'd10, expFlag: 1'b0}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic zeroCount();
    clkMode = 2'b00;
    countWrite = 1'b1;
    cyc(1);
    countWrite = 1'b0;
    ovfClear = 1'b1;
    cyc(1);
    ovfClear = 1'b0;
  endtask

  task automatic capPulse(input logic [3:0] bits);
    chanCapture = bits;
    cyc(1);
    chanCapture = '0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    check(count == 0 && !ovfFlag && !ovfIrq, "R1 reset state", count, 0);
    rstN = 1'b1;
    cyc(2);
    check(count == 0, "R1 count after reset release", count, 0);

    // table of prescale / modulo / direction cases
    for (int i = 0; i < NumVec; i++) begin
      prescaleSel = Vecs[i].ps;
      modulo      = Vecs[i].mdl;
      centerAlign = Vecs[i].ctr;
      zeroCount();
      clkMode = 2'b01;
      cyc(int'(Vecs[i].cyc));
      clkMode = 2'b00;
      check(count == Vecs[i].expCnt,
            Vecs[i].ctr ? "R2/R4 count" : "R2/R3 count", count, Vecs[i].expCnt);
      check(ovfFlag == Vecs[i].expFlag,
            Vecs[i].ctr ? "R4 flag" : "R3 flag", ovfFlag, Vecs[i].expFlag);
      cyc(5);
      check(count == Vecs[i].expCnt, "R2 disabled hold", count, Vecs[i].expCnt);
    end
    prescaleSel = 3'd0;
    centerAlign = 1'b0;

    // R6: interrupt gating, clear, direct write
    modulo = 16'd2;
    zeroCount();
    clkMode = 2'b01;
    cyc(3);
    clkMode = 2'b00;
    check(ovfFlag && !ovfIrq, "R6 irq masked", ovfIrq, 0);
    ovfIrqEn = 1'b1;
    #1;
    check(ovfIrq, "R6 irq enabled", ovfIrq, 1);
    ovfClear = 1'b1;
    cyc(1);
    ovfClear = 1'b0;
    check(!ovfFlag && !ovfIrq, "R6 flag cleared", ovfFlag, 0);
    ovfIrqEn = 1'b0;
    modulo = 16'd1000;
    zeroCount();
    clkMode = 2'b01;
    cyc(7);
    check(count == 7, "R6 pre-write count", count, 7);
    countWrite = 1'b1;
    cyc(1);
    countWrite = 1'b0;
    check(count == 0, "R6 count write", count, 0);
    cyc(2);
    check(count == 2, "R6 resume after write", count, 2);

    // R5: external clock pin edges
    zeroCount();
    clkMode = 2'b10;
    extClkPin = 1'b1;
    cyc(10);
    check(count == 1, "R5 long high pulse counts once", count, 1);
    extClkPin = 1'b0;
    cyc(4);
    for (int k = 0; k < 4; k++) begin
      extClkPin = 1'b1; cyc(4);
      extClkPin = 1'b0; cyc(4);
    end
    check(count == 5, "R5 edge count", count, 5);

    // R7: start on external trigger
    startOnTrig = 1'b1;
    zeroCount();
    clkMode = 2'b01;
    cyc(10);
    check(count == 0, "R7 held before trigger", count, 0);
    extTrigPin = 1'b1; cyc(3);
    extTrigPin = 1'b0; cyc(10);
    check(count >= 5 && count <= 13, "R7 started by trigger", count, 10);

    // R10: active-low external trigger
    trigActiveLow = 1'b1;
    zeroCount();
    extTrigPin = 1'b1;
    cyc(5);
    clkMode = 2'b01;
    cyc(10);
    check(count == 0, "R10 rising edge ignored when active low", count, 0);
    extTrigPin = 1'b0;
    cyc(10);
    check(count > 0, "R10 falling edge starts", count, 1);
    trigActiveLow = 1'b0;

    // R10: internal masked capture trigger
    trigInternal = 1'b1;
    trigMask = 4'b0100;
    zeroCount();
    clkMode = 2'b01;
    capPulse(4'b0001);
    cyc(5);
    check(count == 0, "R10 unmasked channel ignored", count, 0);
    capPulse(4'b0100);
    cyc(5);
    check(count == 5, "R10 masked channel starts", count, 5);

    // R8: stop on overflow, restart by trigger
    startOnTrig = 1'b0;
    stopOnOvf = 1'b1;
    modulo = 16'd3;
    zeroCount();
    clkMode = 2'b01;
    cyc(20);
    check(count == 0 && ovfFlag, "R8 stopped at overflow", count, 0);
    cyc(5);
    check(count == 0, "R8 stays stopped", count, 0);
    startOnTrig = 1'b1;
    capPulse(4'b0100);
    cyc(2);
    check(count == 2, "R8 restart by trigger", count, 2);
    stopOnOvf = 1'b0;
    startOnTrig = 1'b0;

    // R9: reload on trigger
    reloadOnTrig = 1'b1;
    modulo = 16'd1000;
    zeroCount();
    clkMode = 2'b01;
    cyc(50);
    check(count == 50, "R9 pre-reload", count, 50);
    capPulse(4'b0100);
    check(count == 0, "R9 reload", count, 0);
    cyc(3);
    check(count == 3, "R9 count after reload", count, 3);

    // R9: reload coincides with wrap
    modulo = 16'd5;
    zeroCount();
    clkMode = 2'b01;
    cyc(5);
    check(count == 5, "R9 at modulo", count, 5);
    capPulse(4'b0100);
    check(count == 0 && !ovfFlag, "R9 reload beats wrap", ovfFlag, 0);
    cyc(2);
    check(count == 2 && !ovfFlag, "R9 resume after collision", count, 2);

    // R11: doze and debug freeze
    modulo = 16'd1000;
    zeroCount();
    clkMode = 2'b01;
    cyc(10);
    dozePauseEn = 1'b1; dozeActive = 1'b1;
    cyc(10);
    check(count == 10, "R11 doze freeze", count, 10);
    capPulse(4'b0100);
    cyc(2);
    check(count == 10, "R11 trigger ignored while frozen", count, 10);
    dozeActive = 1'b0;
    cyc(3);
    check(count == 13, "R11 resume after doze", count, 13);
    dozePauseEn = 1'b0; dozeActive = 1'b1;
    cyc(2);
    check(count == 15, "R11 doze without pause enable runs", count, 15);
    dozeActive = 1'b0;
    debugActive = 1'b1; debugRunMode = 2'b00;
    cyc(4);
    check(count == 15, "R11 debug freeze", count, 15);
    debugRunMode = 2'b11;
    cyc(4);
    check(count == 19, "R11 debug run mode", count, 19);
    debugActive = 1'b0;
    clkMode = 2'b00;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule